// File: doc/BRIEF.md
# On-Chip Memory Partition Selector

This block decides, for every task launch, how a 64 KB on-chip memory array is divided between software-managed scratchpad and L1 cache. A launch request carries the task's own split preference, the preference of the context it runs in, and the amount of scratchpad the task needs. The preference is resolved in a cascade. A task with a preference uses it. A task without one takes the context's preference. When neither has a preference, the split used by the most recently accepted launch is reused. If the resolved split cannot hold the required scratchpad, the selector overrides it with the smallest split that does.

Requests arrive on a valid/ready channel and results leave on a second valid/ready channel, which has a one-entry output register. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is taken. A plain `enlarged` control pin selects a larger variant of the memory, which has 64 KB of extra scratchpad in every split. The block does not resize any cache or flush any lines. It only produces the decision.

Top module: `mem_split_sel`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the remembered last-used split is scratch-heavy (code 2'b01). A first request with no task or context preference therefore gets 48 KB scratchpad and 16 KB L1.
- R2: Split codes map to sizes as follows: 2'b01 gives 48 KB scratchpad / 16 KB L1, 2'b10 gives 16 KB / 48 KB, and 2'b11 gives 32 KB / 32 KB. The preference code 2'b00 means no preference and is never reported as a split.
- R3: A nonzero task preference is used as the split when its scratchpad holds the requirement.
- R4: A task preference of 2'b00 defers to a nonzero context preference.
- R5: When both preferences are 2'b00, the split of the most recently accepted launch is reused.
- R6: If the requirement exceeds the scratchpad of the resolved split, the reported split is the one with the smallest scratchpad that still holds the requirement.
- R7: A requirement above 48 KB is rejected. The response has `rsp_reject`=1 and `rsp_accepted`=0 and reports the current last-used split, and the last-used split is left unchanged.
- R8: The last-used split updates only on an accepted launch, at the edge that takes the request. A request taken in the very next cycle already sees the new value.
- R9: With `enlarged`=1 (sampled when the request is taken), each split's scratchpad grows by 64 KB (112/80/96 KB for codes 01/10/11) while L1 stays the same. The per-task limit stays 48 KB.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` low, every response output stays stable.
- R11: Every response has exactly one of `rsp_accepted` and `rsp_reject` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enlarged | input | 1 | Enlarged-memory variant select |
| req_valid | input | 1 | Launch request valid (launch strobe) |
| req_ready | output | 1 | Launch request can be taken |
| req_task_pref | input | 2 | Task split preference (00 none) |
| req_ctx_pref | input | 2 | Context split preference (00 none) |
| req_need_kb | input | 8 | Required scratchpad in KB |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_split | output | 2 | Chosen split code |
| rsp_scratch_kb | output | 8 | Scratchpad size in KB |
| rsp_l1_kb | output | 8 | L1 size in KB |
| rsp_accepted | output | 1 | Launch accepted |
| rsp_reject | output | 1 | No split can satisfy the requirement |

## Verification
The hardest case to reach from the ports is the sequence in which the last-used register matters: a request with no preferences whose answer depends on an earlier launch. This includes a launch taken in the cycle right after an update, and a launch that follows a rejected one. The stimulus sends requests back to back so that each launch is taken the cycle after the previous one. It places no-preference requests directly after overrides and rejections. It also runs a pseudo-random stream while the consumer stalls the output at irregular intervals, so that a remembered split has to survive held responses.

// File: rtl/msel_pkg.sv
package msel_pkg;
  typedef logic [1:0] split_t;

  localparam split_t SPLIT_NONE = 2'b00;
  localparam split_t SPLIT_SCR  = 2'b01;
  localparam split_t SPLIT_L1   = 2'b10;
  localparam split_t SPLIT_EQ   = 2'b11;

  // Scratchpad share of the base array for a split code.
  function automatic int unsigned scr_of(split_t s, int unsigned base_kb);
    case (s)
      SPLIT_L1: scr_of = base_kb / 4;
      SPLIT_EQ: scr_of = base_kb / 2;
      default:  scr_of = (base_kb * 3) / 4;
    endcase
  endfunction
endpackage

// File: rtl/msel_resolve.sv
module msel_resolve
  import msel_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic [1:0] task_pref,
  input  logic [1:0] ctx_pref,
  input  logic [1:0] last_split,
  output logic [1:0] resolved
);
  // Candidates in priority order: task, context, last-used.
  split_t cand [LEVELS];

  assign cand[0] = task_pref;
  assign cand[1] = ctx_pref;
  assign cand[LEVELS-1] = last_split;

  always_comb begin
    resolved = cand[LEVELS-1];
    for (int i = LEVELS - 2; i >= 0; i--) begin
      if (cand[i] != SPLIT_NONE) resolved = cand[i];
    end
  end
endmodule

// File: rtl/msel_fit.sv
module msel_fit
  import msel_pkg::*;
#(
  parameter int BASE_KB  = 64,
  parameter int EXTRA_KB = 64,
  parameter int LIMIT_KB = 48,
  parameter int REQ_W    = 8,
  parameter int SZ_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enlarged,
  input  logic [REQ_W-1:0] need_kb,
  input  logic [1:0]       resolved,
  input  logic [1:0]       last_split,
  output logic [1:0]       choice,
  output logic             reject
);
  localparam int NCODES = 3;

  int unsigned cap [0:NCODES];
  int unsigned need_i;
  int unsigned best_cap;
  split_t      best;

  assign need_i = 32'(need_kb);
  assign cap[0] = 0;

  generate
    for (genvar g = 1; g <= NCODES; g++) begin : g_cap
      assign cap[g] = scr_of(split_t'(g), BASE_KB) + (enlarged ? EXTRA_KB : 0);
    end
  endgenerate

  // Smallest scratchpad that still holds the requirement.
  always_comb begin
    best     = SPLIT_SCR;
    best_cap = 32'hFFFF_FFFF;
    for (int c = 1; c <= NCODES; c++) begin
      if (cap[c] >= need_i && cap[c] < best_cap) begin
        best     = split_t'(c);
        best_cap = cap[c];
      end
    end
  end

  always_comb begin
    reject = need_i > LIMIT_KB;
    if (reject)                       choice = last_split;
    else if (cap[resolved] >= need_i) choice = resolved;
    else                              choice = best;
  end

  // R6: a non-rejected choice always holds the requirement.
  assert_choice_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reject |-> cap[choice] >= need_i);

  // R9: the requirement limit does not grow with the enlarged variant.
  assert_limit_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (need_i > LIMIT_KB) |-> reject);
endmodule

// File: rtl/msel_state.sv
module msel_state
  import msel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [1:0] nxt,
  output logic [1:0] last_split
);
  always_ff @(posedge clk) begin
    if (!rst_n)   last_split <= SPLIT_SCR;
    else if (upd) last_split <= nxt;
  end

  // R1: the first cycle after reset holds the scratch-heavy split.
  assert_reset_split_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> last_split == SPLIT_SCR);

  // R7: without an accepted launch the remembered split stays.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(last_split));

  // R8: an accepted launch is visible the next cycle.
  assert_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> last_split == $past(nxt));

  // R2: the remembered split is never the no-preference code.
  assert_never_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_split != SPLIT_NONE);
endmodule

// File: rtl/mem_split_sel.sv
module mem_split_sel
  import msel_pkg::*;
#(
  parameter int BASE_KB  = 64,
  parameter int EXTRA_KB = 64,
  parameter int LIMIT_KB = 48,
  parameter int REQ_W    = 8,
  parameter int SZ_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enlarged,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_task_pref,
  input  logic [1:0]       req_ctx_pref,
  input  logic [REQ_W-1:0] req_need_kb,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_split,
  output logic [SZ_W-1:0]  rsp_scratch_kb,
  output logic [SZ_W-1:0]  rsp_l1_kb,
  output logic             rsp_accepted,
  output logic             rsp_reject
);
  localparam int TOTAL_KB = BASE_KB + EXTRA_KB;

  logic [1:0] last_split;
  logic [1:0] resolved;
  logic [1:0] choice;
  logic       reject;
  logic       fire;
  logic       enl_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  msel_resolve #(.LEVELS(3)) u_resolve (
    .task_pref (req_task_pref),
    .ctx_pref  (req_ctx_pref),
    .last_split(last_split),
    .resolved  (resolved)
  );

  msel_fit #(
    .BASE_KB (BASE_KB),
    .EXTRA_KB(EXTRA_KB),
    .LIMIT_KB(LIMIT_KB),
    .REQ_W   (REQ_W),
    .SZ_W    (SZ_W)
  ) u_fit (
    .clk       (clk),
    .rst_n     (rst_n),
    .enlarged  (enlarged),
    .need_kb   (req_need_kb),
    .resolved  (resolved),
    .last_split(last_split),
    .choice    (choice),
    .reject    (reject)
  );

  msel_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (fire && !reject),
    .nxt       (choice),
    .last_split(last_split)
  );

  // One-entry output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_split    <= SPLIT_SCR;
      rsp_accepted <= 1'b0;
      rsp_reject   <= 1'b0;
      enl_q        <= 1'b0;
    end else if (fire) begin
      rsp_valid    <= 1'b1;
      rsp_split    <= choice;
      rsp_accepted <= !reject;
      rsp_reject   <= reject;
      enl_q        <= enlarged;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  assign rsp_scratch_kb = SZ_W'(scr_of(rsp_split, BASE_KB) + (enl_q ? EXTRA_KB : 0));
  assign rsp_l1_kb      = SZ_W'(BASE_KB - scr_of(rsp_split, BASE_KB));

  // R10: a stalled response holds every field.
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_split) &&
      $stable(rsp_scratch_kb) && $stable(rsp_l1_kb) &&
      $stable(rsp_accepted) && $stable(rsp_reject));

  // R11: exactly one outcome per response.
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_accepted, rsp_reject}) == 1);

  // R9: the two sizes always add up to the array of the selected variant.
  assert_size_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(rsp_scratch_kb) + 32'(rsp_l1_kb)) ==
                  (enl_q ? TOTAL_KB : BASE_KB));
endmodule

// File: tb/mem_split_sel_test.sv
module mem_split_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enlarged = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_task_pref = 2'b00;
  logic [1:0] req_ctx_pref = 2'b00;
  logic [7:0] req_need_kb = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [1:0] rsp_split;
  logic [7:0] rsp_scratch_kb;
  logic [7:0] rsp_l1_kb;
  logic       rsp_accepted;
  logic       rsp_reject;

  always #5 clk = ~clk;

  mem_split_sel uut (
    .clk(clk), .rst_n(rst_n), .enlarged(enlarged),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_task_pref(req_task_pref), .req_ctx_pref(req_ctx_pref),
    .req_need_kb(req_need_kb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_split(rsp_split), .rsp_scratch_kb(rsp_scratch_kb),
    .rsp_l1_kb(rsp_l1_kb), .rsp_accepted(rsp_accepted),
    .rsp_reject(rsp_reject)
  );

  typedef struct {
    logic [1:0] split;
    int         scr;
    int         l1;
    bit         acc;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [1:0] m_last = 2'b01;
  bit         m_enl = 0;
  bit         bp_on = 0;
  bit         done = 0;
  logic [15:0] bp_lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int scr_kb(logic [1:0] s);
    case (s)
      2'b10:   return 16;
      2'b11:   return 32;
      default: return 48;
    endcase
  endfunction

  // Driver: presents one request, pushes the expected decision when taken.
  task automatic send(logic [1:0] tp, logic [1:0] cp, int need, string tag);
    exp_t       e;
    logic [1:0] r;
    int         extra;
    @(posedge clk); #1;
    req_task_pref = tp; req_ctx_pref = cp; req_need_kb = 8'(need);
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    extra = m_enl ? 64 : 0;
    e.tag = tag;
    if (need > 48) begin
      e.split = m_last; e.acc = 0;
    end else begin
      r = (tp != 2'b00) ? tp : ((cp != 2'b00) ? cp : m_last);
      if (need > scr_kb(r) + extra)
        r = (need <= 16) ? 2'b10 : ((need <= 32) ? 2'b11 : 2'b01);
      e.split = r; e.acc = 1;
      m_last = r;
    end
    e.scr = scr_kb(e.split) + extra;
    e.l1  = 64 - scr_kb(e.split);
    sb.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic set_enl(bit v);
    @(posedge clk); #1;
    enlarged = v; m_enl = v;
  endtask

  // Consumer readiness pattern.
  initial begin
    forever begin
      @(posedge clk); #1;
      bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      rsp_ready = bp_on ? bp_lfsr[0] : 1'b1;
    end
  end

  // Monitor: compares every delivered decision against the scoreboard.
  logic       hold_pend = 0;
  logic [1:0] h_split;
  logic [7:0] h_scr, h_l1;
  logic       h_acc, h_rej;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(rsp_valid && rsp_split == h_split && rsp_scratch_kb == h_scr &&
            rsp_l1_kb == h_l1 && rsp_accepted == h_acc && rsp_reject == h_rej,
            "R10", "stalled response changed (split)", int'(rsp_split), int'(h_split));
        hold_pend = 0;
      end
      if (rsp_valid && !rsp_ready) begin
        hold_pend = 1;
        h_split = rsp_split; h_scr = rsp_scratch_kb; h_l1 = rsp_l1_kb;
        h_acc = rsp_accepted; h_rej = rsp_reject;
        chk(!req_ready, "R10", "ready while stalled", int'(req_ready), 0);
      end
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R11", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_split == e.split, e.tag, "split", int'(rsp_split), int'(e.split));
          chk(int'(rsp_scratch_kb) == e.scr && int'(rsp_l1_kb) == e.l1, e.tag,
              "scratch KB", int'(rsp_scratch_kb), e.scr);
          chk(rsp_accepted == e.acc && rsp_reject == !e.acc, e.tag,
              "accepted", int'(rsp_accepted), int'(e.acc));
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rl;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);

    // Directed sequence, issued back to back.
    send(2'b00, 2'b00, 0,  "R1 reset split");
    send(2'b10, 2'b01, 8,  "R3 task pref L1");
    send(2'b00, 2'b00, 0,  "R8 next-cycle reuse");
    send(2'b00, 2'b11, 20, "R4 context pref");
    send(2'b00, 2'b00, 16, "R5 last used");
    send(2'b10, 2'b01, 40, "R6 override to 48");
    send(2'b10, 2'b00, 24, "R6 override smallest 32");
    send(2'b01, 2'b01, 60, "R7 reject");
    send(2'b00, 2'b00, 0,  "R7 last kept");
    send(2'b11, 2'b00, 32, "R2 equal split");
    send(2'b00, 2'b00, 49, "R7 reject just over");
    send(2'b01, 2'b10, 48, "R3 limit exactly");
    idle();

    set_enl(1'b1);
    send(2'b10, 2'b00, 40, "R9 enlarged no override");
    send(2'b01, 2'b00, 0,  "R9 enlarged scratch-heavy");
    send(2'b11, 2'b00, 0,  "R9 enlarged equal");
    send(2'b00, 2'b00, 49, "R9 enlarged reject");
    idle();
    set_enl(1'b0);

    // Pseudo-random stream under back-pressure.
    bp_on = 1;
    rl = 16'h1D2B;
    for (int i = 0; i < 80; i++) begin
      rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
      send(rl[1:0], rl[3:2], int'(rl[9:4]), "R5 R6 R10 random");
      if (rl[11]) idle();
    end
    idle();
    bp_on = 0;

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "trailing response", int'(rsp_valid), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule